// File: doc/BRIEF.md
# Six-Pin Bidirectional I/O Port

This block is a six-pin parallel port that sits on a simple register bus. Two registers control it. The data register holds the levels that output pins drive. The direction register chooses, for each pin, whether the output driver is enabled. Each pin has its own read multiplexer. It returns the latched data bit when the pin acts as an output, and the synchronised pad level when it acts as an input. The per-pin output enables go straight to the pad tri-state controls.

Two pins have a fixed role. Pin 5 can only be an input and pin 4 can only be an output, so the direction bits at those positions do not change their behaviour. Those two direction bits are still stored and read back. Pad inputs pass through a two-flop synchroniser before they reach the read path.

Top module: `sixpin_io_port`

## Requirements
- R1: While `rst_n` is low, both registers clear to zero. After reset, `pad_out` is 0, `pad_oe` is 6'b010000 (only the output-only pin 4 is enabled), and reads of either register return 0 while the pads are low.
- R2: Address 0 selects the data register and address 1 selects the direction register. Read bits 7:6 are always zero, and writes to bits 7:6 have no effect.
- R3: A write takes effect on the rising clock edge at which `bus_we` is high. A data write latches all six bits whatever each pin's direction, so a pin switched to output later drives the value written earlier.
- R4: For pins 0 to 3 with direction bit 1, `pad_oe` is 1, `pad_out` carries the latched data bit, and a data read returns the latched bit.
- R5: For pins 0 to 3 with direction bit 0, `pad_oe` is 0 and a data read returns the synchronised pad level.
- R6: Pin 5 is input-only. `pad_oe[5]` is always 0 and data-read bit 5 is always the synchronised pad level, whatever direction bit 5 holds.
- R7: Pin 4 is output-only. `pad_oe[4]` is always 1 and data-read bit 4 is always the latched data bit, whatever direction bit 4 holds.
- R8: A pad change present at a rising edge appears in data reads after the second rising edge, and not after the first.
- R9: All six direction bits, including bits 4 and 5, read back exactly as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 1 | Register select: 0 selects data, 1 selects direction |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| pad_in | input | 6 | Pad input levels |
| pad_out | output | 6 | Pad output levels |
| pad_oe | output | 6 | Pad output enables |

## Verification
The hardest case to reach is a pin whose direction bit disagrees with its fixed role. To reach it, direction bit 5 is set while pad 5 differs from data bit 5, and direction bit 4 is cleared while pad 4 differs from data bit 4. The vector table mixes these conflicting settings with ordinary pins, so the read path and the enables on the fixed pins show the fixed role. A directed test writes data while a pin is an input and then turns the pin into an output, which shows the earlier value being driven. Another directed test changes a pad at a falling edge and reads after each of the next two rising edges to confirm the two-stage latency.

// File: rtl/sixpin_io_pkg.sv
package sixpin_io_pkg;
  localparam int PORT_W = 6;
  localparam int BUS_W  = 8;
  localparam int IN_ONLY_PIN  = 5;
  localparam int OUT_ONLY_PIN = 4;

  typedef logic [PORT_W-1:0] pin_vec_t;

  // Direction actually applied: fixed pins override the stored bit.
  function automatic pin_vec_t eff_dir(input pin_vec_t dir);
    pin_vec_t r;
    r = dir;
    r[IN_ONLY_PIN]  = 1'b0;
    r[OUT_ONLY_PIN] = 1'b1;
    return r;
  endfunction

  // Output pins return latched data, input pins return the synced pad level.
  function automatic pin_vec_t read_mux(input pin_vec_t edir, input pin_vec_t data,
                                        input pin_vec_t pins);
    return (edir & data) | (~edir & pins);
  endfunction
endpackage

// File: rtl/sixpin_io_sync.sv
module sixpin_io_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= async_in;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];

      AST_STAGE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> stage_q[s] == $past(stage_q[s-1])); // R8
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/sixpin_io_regs.sv
module sixpin_io_regs
  import sixpin_io_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_addr,
  input  logic             bus_we,
  input  logic [BUS_W-1:0] bus_wdata,
  output pin_vec_t         data_q,
  output pin_vec_t         dir_q
);
  logic wr_data_ev, wr_dir_ev;
  assign wr_data_ev = bus_we && (bus_addr == 1'b0);
  assign wr_dir_ev  = bus_we && (bus_addr == 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      if (wr_data_ev) data_q <= bus_wdata[PORT_W-1:0];
      if (wr_dir_ev)  dir_q  <= bus_wdata[PORT_W-1:0];
    end
  end

  AST_DATA_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data_ev |=> data_q == $past(bus_wdata[PORT_W-1:0])); // R3
  AST_DIR_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir_ev |=> dir_q == $past(bus_wdata[PORT_W-1:0])); // R9
  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(data_q) && $stable(dir_q)); // R3
endmodule

// File: rtl/sixpin_io_pinctl.sv
module sixpin_io_pinctl
  import sixpin_io_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  pin_vec_t data_q,
  input  pin_vec_t dir_q,
  input  pin_vec_t pins_sync,
  output pin_vec_t rd_pins,
  output pin_vec_t pad_out,
  output pin_vec_t pad_oe
);
  pin_vec_t edir;
  assign edir    = eff_dir(dir_q);
  assign pad_oe  = edir;
  assign pad_out = data_q;
  assign rd_pins = read_mux(edir, data_q, pins_sync);

  AST_IN_ONLY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    dir_q[IN_ONLY_PIN] |-> !pad_oe[IN_ONLY_PIN] && rd_pins[IN_ONLY_PIN] == pins_sync[IN_ONLY_PIN]); // R6
  AST_OUT_ONLY_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_q[OUT_ONLY_PIN] |-> pad_oe[OUT_ONLY_PIN] && rd_pins[OUT_ONLY_PIN] == data_q[OUT_ONLY_PIN]); // R7
endmodule

// File: rtl/sixpin_io_port.sv
module sixpin_io_port
  import sixpin_io_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_addr,
  input  logic             bus_we,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic [5:0]       pad_in,
  output logic [5:0]       pad_out,
  output logic [5:0]       pad_oe
);
  pin_vec_t data_q, dir_q, pins_sync, rd_pins;

  sixpin_io_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .data_q(data_q), .dir_q(dir_q)
  );

  sixpin_io_sync #(.WIDTH(PORT_W), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(pins_sync)
  );

  sixpin_io_pinctl u_pinctl (
    .clk(clk), .rst_n(rst_n), .data_q(data_q), .dir_q(dir_q),
    .pins_sync(pins_sync), .rd_pins(rd_pins), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == 1'b0) bus_rdata[PORT_W-1:0] = rd_pins;
    else                  bus_rdata[PORT_W-1:0] = dir_q;
  end

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[BUS_W-1:PORT_W] == '0); // R2
  AST_RESET_STATE: assert property (@(posedge clk)
    !rst_n |-> data_q == '0 && dir_q == '0 && pad_oe == 6'b010000); // R1
endmodule

// File: tb/sixpin_io_port_tb.sv
module sixpin_io_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_addr = 1'b0;
  logic bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [5:0] pad_in = '0;
  logic [5:0] pad_out, pad_oe;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sixpin_io_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // Columns: dir, data, pad, expected read, expected oe, expected out
  localparam logic [35:0] VEC [5] = '{
    {6'h3F, 6'h2A, 6'h15, 6'h0A, 6'h1F, 6'h2A},
    {6'h00, 6'h15, 6'h3F, 6'h3F, 6'h10, 6'h15},
    {6'h0A, 6'h3C, 6'h21, 6'h39, 6'h1A, 6'h3C},
    {6'h25, 6'h03, 6'h2C, 6'h29, 6'h15, 6'h03},
    {6'h10, 6'h00, 6'h1F, 6'h0F, 6'h10, 6'h00}
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] r;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    rd(1'b0, r); check("R1 data read", r, 8'h00);
    rd(1'b1, r); check("R1 dir read", r, 8'h00);
    check("R1 oe", {2'b0, pad_oe}, 8'h10);
    check("R1 out", {2'b0, pad_out}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // Vector walk: R4 R5 R6 R7 R9 R2
    for (int i = 0; i < 5; i++) begin
      wr(1'b1, {2'b11, VEC[i][35:30]});
      wr(1'b0, {2'b11, VEC[i][29:24]});
      pad_in = VEC[i][23:18];
      repeat (2) @(negedge clk);
      rd(1'b0, r); check("R4/R5/R6/R7 data read", r, {2'b00, VEC[i][17:12]});
      rd(1'b1, r); check("R9/R2 dir read", r, {2'b00, VEC[i][35:30]});
      check("R4/R6/R7 oe", {2'b0, pad_oe}, {2'b0, VEC[i][11:6]});
      check("R4 out", {2'b0, pad_out}, {2'b0, VEC[i][5:0]});
    end

    // R3: data written while input, driven once switched to output
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h05);
    pad_in = 6'h00;
    repeat (2) @(negedge clk);
    check("R3 oe still off", {2'b0, pad_oe}, 8'h10);
    rd(1'b0, r); check("R3 input reads pad", r, 8'h00);
    wr(1'b1, 8'h0F);
    check("R3 earlier data driven", {2'b0, pad_out & pad_oe}, 8'h05);
    rd(1'b0, r); check("R3 earlier data read", r, 8'h05);

    // R8 latency: pad change at falling edge
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h00);
    pad_in = 6'h00;
    repeat (3) @(negedge clk);
    pad_in = 6'h01;
    @(negedge clk);
    rd(1'b0, r); check("R8 not after one edge", r, 8'h00);
    @(negedge clk);
    rd(1'b0, r); check("R8 visible after two edges", r, 8'h01);

    // R6: pin 5 held input even with its direction bit set
    wr(1'b1, 8'h20);
    wr(1'b0, 8'h20);
    pad_in = 6'h00;
    repeat (2) @(negedge clk);
    rd(1'b0, r); check("R6 pin5 reads pad", r, 8'h00);
    check("R6 pin5 oe", {7'b0, pad_oe[5]}, 8'h00);

    // R7: pin 4 output with its direction bit clear
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h10);
    rd(1'b0, r); check("R7 pin4 reads data", r, 8'h10);
    check("R7 pin4 out", {7'b0, pad_out[4]}, 8'h01);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule